// File: doc/BRIEF.md
# Uniform Two-Bit Carry Select Adder Built from Constant-Table Multiplexers

This block is a purely combinational binary adder with a parameterised, even word width. It adds two unsigned operands and a carry-in, and returns the word sum and a carry-out. The intended use is as the adder stage of a multiply-accumulate or filter datapath where cell area and switching activity matter more than the length of the carry path.

The word is cut into equal two-bit slices. The lowest slice adds directly with the external carry-in. Every higher slice computes its two-bit result twice in parallel: once assuming no carry arrives and once assuming a carry arrives. The true carry from the slice below then picks one of the two results. Every XOR, AND and OR inside a slice is a four-input multiplexer whose data inputs are tied to constants and whose two select lines carry the logic operands. This gives a single repeated cell type across the netlist. An odd width is refused at elaboration.

Top module: `csla_mux_adder`

## Requirements
- R1: For every input, the concatenation {cout, sum} equals the unsigned value a + b + cin taken to WIDTH+1 bits.
- R2: The lowest two-bit slice adds the external carry-in directly: sum[1:0] equals the low two bits of a[1:0] + b[1:0] + cin.
- R3: A carry generated at the top bit of one slice reaches the next slice only through that slice's result selector, so a + b where both operands hold a single 1 at bit 2k+1 gives a sum with a single 1 at bit 2k+2 (and cout set when 2k+2 equals WIDTH).
- R4: With a all ones, b zero and cin 1, the carry ripples through every slice: sum is zero and cout is 1.
- R5: With both operands zero and cin 0, sum and cout are zero.
- R6: With a = 0101...01 and b = 1010...10, the sum is all ones and cout is 0 when cin is 0, and the sum is zero and cout is 1 when cin is 1.
- R7: With a and b all ones and cin 1, sum is all ones and cout is 1.
- R8: The block holds no state: a change of a, b or cin shows at sum and cout without any clock edge.
- R9: The same source produces a correct adder at widths 8, 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
A wrong constant table in one multiplexer, or a selector wired to the wrong slice carry, corrupts only the bits from that slice upward and only for operand patterns that exercise the faulty term, so the error shows at the ports immediately, with no latency, but only under the right data. The carry-chain patterns (all ones with a carry-in, alternating bits, a single injected carry at each slice boundary) drive every selector through both choices, and the exhaustive sweep at eight bits hits every table entry of every cell type.

// File: rtl/csla_mux_pkg.sv
package csla_mux_pkg;
  // Constant data words for the 4:1 logic multiplexer, bit index = {sel_hi, sel_lo}.
  localparam logic [3:0] LUT_XOR = 4'b0110;
  localparam logic [3:0] LUT_AND = 4'b1000;
  localparam logic [3:0] LUT_OR  = 4'b1110;
  // Bits per selectable slice.
  localparam int unsigned SLICE_W = 2;
endpackage

// File: rtl/mux_lut.sv
module mux_lut #(
  parameter logic [3:0] TBL = 4'b0000
) (
  input  logic sel_hi,
  input  logic sel_lo,
  output logic y
);
  always_comb begin
    y = TBL[{sel_hi, sel_lo}];
  end
endmodule

// File: rtl/slice_add_zero.sv
// Two-bit adder with carry-in known to be zero: seven table multiplexers.
module slice_add_zero
  import csla_mux_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [1:0] s,
  output logic       co
);
  logic c_lo, p_hi, g_hi, t_hi;

  mux_lut #(.TBL(LUT_XOR)) u_s0 (.sel_hi(a[0]), .sel_lo(b[0]), .y(s[0]));
  mux_lut #(.TBL(LUT_AND)) u_c0 (.sel_hi(a[0]), .sel_lo(b[0]), .y(c_lo));
  mux_lut #(.TBL(LUT_XOR)) u_p1 (.sel_hi(a[1]), .sel_lo(b[1]), .y(p_hi));
  mux_lut #(.TBL(LUT_AND)) u_g1 (.sel_hi(a[1]), .sel_lo(b[1]), .y(g_hi));
  mux_lut #(.TBL(LUT_XOR)) u_s1 (.sel_hi(p_hi), .sel_lo(c_lo), .y(s[1]));
  mux_lut #(.TBL(LUT_AND)) u_t1 (.sel_hi(p_hi), .sel_lo(c_lo), .y(t_hi));
  mux_lut #(.TBL(LUT_OR))  u_co (.sel_hi(g_hi), .sel_lo(t_hi), .y(co));
endmodule

// File: rtl/slice_add_var.sv
// Two-bit adder with a live carry-in: five table multiplexers per bit.
module slice_add_var
  import csla_mux_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic       ci,
  output logic [1:0] s,
  output logic       co
);
  logic [2:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    logic prop, gen, term;
    mux_lut #(.TBL(LUT_XOR)) u_p (.sel_hi(a[i]),  .sel_lo(b[i]),     .y(prop));
    mux_lut #(.TBL(LUT_AND)) u_g (.sel_hi(a[i]),  .sel_lo(b[i]),     .y(gen));
    mux_lut #(.TBL(LUT_XOR)) u_s (.sel_hi(prop),  .sel_lo(chain[i]), .y(s[i]));
    mux_lut #(.TBL(LUT_AND)) u_t (.sel_hi(prop),  .sel_lo(chain[i]), .y(term));
    mux_lut #(.TBL(LUT_OR))  u_c (.sel_hi(gen),   .sel_lo(term),     .y(chain[i+1]));
  end

  assign co = chain[SLICE_W];
endmodule

// File: rtl/slice_pick.sv
// Chooses between the two precomputed slice results using the incoming carry.
module slice_pick
  import csla_mux_pkg::*;
(
  input  logic               sel,
  input  logic [SLICE_W-1:0] s_c0,
  input  logic               co_c0,
  input  logic [SLICE_W-1:0] s_c1,
  input  logic               co_c1,
  output logic [SLICE_W-1:0] s,
  output logic               co
);
  always_comb begin
    s  = sel ? s_c1  : s_c0;
    co = sel ? co_c1 : co_c0;
  end
endmodule

// File: rtl/csla_mux_adder.sv
module csla_mux_adder
  import csla_mux_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  if ((WIDTH % SLICE_W) != 0 || WIDTH < SLICE_W) begin : g_bad_width
    $error("csla_mux_adder: WIDTH must be a positive even number");
  end

  logic [NSLICE-1:0] slice_co;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    localparam int unsigned LO = k * SLICE_W;
    if (k == 0) begin : g_first
      slice_add_var u_add (
        .a (a[LO +: SLICE_W]),
        .b (b[LO +: SLICE_W]),
        .ci(cin),
        .s (sum[LO +: SLICE_W]),
        .co(slice_co[k])
      );
    end else begin : g_upper
      logic [SLICE_W-1:0] s0, s1;
      logic               c0, c1;
      slice_add_zero u_add0 (
        .a (a[LO +: SLICE_W]),
        .b (b[LO +: SLICE_W]),
        .s (s0),
        .co(c0)
      );
      slice_add_var u_add1 (
        .a (a[LO +: SLICE_W]),
        .b (b[LO +: SLICE_W]),
        .ci(1'b1),
        .s (s1),
        .co(c1)
      );
      slice_pick u_pick (
        .sel  (slice_co[k-1]),
        .s_c0 (s0),
        .co_c0(c0),
        .s_c1 (s1),
        .co_c1(c1),
        .s    (sum[LO +: SLICE_W]),
        .co   (slice_co[k])
      );
    end
  end

  assign cout = slice_co[NSLICE-1];
endmodule

// File: rtl/csla_mux_adder_chk.sv
module csla_mux_adder_chk #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned NSLICE = WIDTH / 2
) (
  input logic [WIDTH-1:0]  a,
  input logic [WIDTH-1:0]  b,
  input logic              cin,
  input logic [WIDTH-1:0]  sum,
  input logic              cout,
  input logic [NSLICE-1:0] slice_co
);
  logic [WIDTH:0] golden;
  logic [2:0]     low_ref;

  always_comb begin
    golden  = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    low_ref = {1'b0, a[1:0]} + {1'b0, b[1:0]} + {2'b00, cin};

    // R1: full-width result matches the unsigned sum
    p_total_r1: assert ({cout, sum} == golden);
    // R2: lowest slice adds the external carry-in
    p_low_slice_r2: assert (sum[1:0] == low_ref[1:0]);
    // R3: each slice carry equals the true carry into the next bit position
    for (int k = 0; k < NSLICE - 1; k++) begin
      p_slice_carry_r3: assert (slice_co[k] == (a[2*k+2] ^ b[2*k+2] ^ golden[2*k+2]));
    end
    // R3: the top slice carry is the block carry-out
    p_top_carry_r3: assert (slice_co[NSLICE-1] == golden[WIDTH]);
    // R4: full propagate with a carry-in ripples to the top
    if ((a ^ b) == {WIDTH{1'b1}} && cin) begin
      p_ripple_r4: assert (sum == '0 && cout);
    end
  end
endmodule

bind csla_mux_adder csla_mux_adder_chk #(.WIDTH(WIDTH), .NSLICE(NSLICE)) u_chk (
  .a       (a),
  .b       (b),
  .cin     (cin),
  .sum     (sum),
  .cout    (cout),
  .slice_co(slice_co)
);

// File: tb/csla_mux_adder_test.sv
module csla_mux_adder_test;
  logic clk;
  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [63:0] x, y;
  logic        c;
  logic [7:0]  s8;  logic co8;
  logic [15:0] s16; logic co16;
  logic [31:0] s32; logic co32;
  logic [63:0] s64; logic co64;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  csla_mux_adder #(.WIDTH(16)) uut   (.a(x[15:0]), .b(y[15:0]), .cin(c), .sum(s16), .cout(co16));
  csla_mux_adder #(.WIDTH(8))  uut8  (.a(x[7:0]),  .b(y[7:0]),  .cin(c), .sum(s8),  .cout(co8));
  csla_mux_adder #(.WIDTH(32)) uut32 (.a(x[31:0]), .b(y[31:0]), .cin(c), .sum(s32), .cout(co32));
  csla_mux_adder #(.WIDTH(64)) uut64 (.a(x),       .b(y),       .cin(c), .sum(s64), .cout(co64));

  task automatic chk(input string req, input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Drive all widths, wait without any clock edge, compare every width (R1, R8, R9).
  task automatic apply(input logic [63:0] xa, input logic [63:0] yb, input logic ci, input string req);
    logic [8:0]  r8;
    logic [16:0] r16;
    logic [32:0] r32;
    logic [64:0] r64;
    x = xa; y = yb; c = ci;
    #1;
    r8  = {1'b0, xa[7:0]}  + {1'b0, yb[7:0]}  + {8'd0, ci};
    r16 = {1'b0, xa[15:0]} + {1'b0, yb[15:0]} + {16'd0, ci};
    r32 = {1'b0, xa[31:0]} + {1'b0, yb[31:0]} + {32'd0, ci};
    r64 = {1'b0, xa}       + {1'b0, yb}       + {64'd0, ci};
    chk({req, " R9 w8"},  {56'd0, co8,  s8},  {56'd0, r8});
    chk({req, " R1 w16"}, {48'd0, co16, s16}, {48'd0, r16});
    chk({req, " R9 w32"}, {32'd0, co32, s32}, {32'd0, r32});
    chk({req, " R9 w64"}, {co64, s64}, r64);
  endtask

  task automatic t_zero_r5;
    apply('0, '0, 1'b0, "R5");
    chk("R5 sum zero", {1'b0, s64}, 65'd0);
    chk("R5 cout zero", {64'd0, co64}, 65'd0);
  endtask

  task automatic t_ripple_r4;
    apply('1, '0, 1'b1, "R4");
    chk("R4 w16 wraps", {48'd0, co16, s16}, {48'd1, 16'd0});
    chk("R4 w64 wraps", {co64, s64}, {1'b1, 64'd0});
  endtask

  task automatic t_alternate_r6;
    apply({32{2'b01}}, {32{2'b10}}, 1'b0, "R6");
    chk("R6 no carry", {co32, s32}, {1'b0, 32'hFFFF_FFFF});
    apply({32{2'b01}}, {32{2'b10}}, 1'b1, "R6");
    chk("R6 carry in", {co32, s32}, {1'b1, 32'd0});
  endtask

  task automatic t_max_r7;
    apply('1, '1, 1'b1, "R7");
    chk("R7 max", {co64, s64}, {1'b1, {64{1'b1}}});
  endtask

  task automatic t_low_slice_r2;
    for (int v = 0; v < 32; v++) begin
      logic [2:0] e;
      apply({62'd0, v[1:0]}, {62'd0, v[3:2]}, v[4], "R2");
      e = {1'b0, v[1:0]} + {1'b0, v[3:2]} + {2'b00, v[4]};
      chk("R2 low slice", {63'd0, s16[1:0]}, {63'd0, e[1:0]});
    end
  endtask

  task automatic t_boundary_r3;
    for (int k = 0; k < 32; k++) begin
      logic [64:0] e;
      apply(64'd1 << (2*k+1), 64'd1 << (2*k+1), 1'b0, "R3");
      e = 65'd1 << (2*k+2);
      chk("R3 slice carry", {co64, s64}, e);
    end
  endtask

  task automatic t_no_clock_r8;
    @(negedge clk);
    #2;
    x = 64'h00FF; y = 64'h0001; c = 1'b0;
    #1;
    chk("R8 first", {48'd0, co16, s16}, 65'h0100);
    y = 64'hFF01;
    #1;
    chk("R8 second", {48'd0, co16, s16}, {48'd0, 17'h1_0000});
  endtask

  task automatic t_exhaustive8_r9;
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        for (int k = 0; k < 2; k++)
          apply({$urandom(), $urandom()} & ~64'hFF | 64'(i), {$urandom(), $urandom()} & ~64'hFF | 64'(j), k[0], "R9 sweep");
  endtask

  task automatic t_random_r1;
    for (int n = 0; n < 2000; n++)
      apply({$urandom(), $urandom()}, {$urandom(), $urandom()}, $urandom() & 1, "R1 random");
  endtask

  initial begin
    x = '0; y = '0; c = 1'b0;
    t_zero_r5();
    t_ripple_r4();
    t_alternate_r6();
    t_max_r7();
    t_low_slice_r2();
    t_boundary_r3();
    t_no_clock_r8();
    t_random_r1();
    t_exhaustive8_r9();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule